// File: doc/BRIEF.md
# Board Control Register Block

This block is a small set of memory-mapped control registers for a development board, reached over a plain 32-bit register bus. Each write is a single-cycle strobe with a byte offset and a data word. Reads are combinational on the offset. The block drives an 8-bit LED bar and holds an eight-character ASCII text buffer for a front-panel display. The buffer can be loaded in two ways. One character can be written at a time, or a whole 32-bit word can be written and is shown as eight uppercase hexadecimal digits.

The block also holds three more registers: a break/reset byte, a general-purpose output byte and a fixed status word. It has a soft-reset trigger that fires only on one magic value. A group of bit-banged two-wire registers drives the clock and data lines of an attached serial EEPROM. On readback, the EEPROM's returned data bit is merged into the input register. A read of any offset the block does not decode returns zero, and a write to such an offset changes nothing.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset the outputs and registers hold these values: LED bar 0x00, break/reset 0x0A, GP output 0x00, two-wire output-enable 0x0, two-wire output 0x3 (so `scl_o`=1 and `sda_o`=1), select 0x1, every display character 0x20 (space), and `soft_rst_req` low.
- R2: Offsets 0x200 (switches) and 0x210 (jumpers) always read 0, and writes to them change nothing. Any offset not listed in R2 through R10 also reads 0 and ignores writes.
- R3: Offset 0x208 reads 0x12 when the parameter `BIG_ENDIAN` is 1, and 0x10 when it is 0.
- R4: A write to 0x408 stores bits [7:0] of the data. That byte appears on `led_o` after the write's clock edge, and a read of 0x408 returns it zero-extended.
- R5: A write to 0x410 replaces all eight display characters with the uppercase hex ASCII digits of the data word ('0'-'9' as 0x30-0x39, 'A'-'F' as 0x41-0x46). Character 0 (`disp_o[7:0]`) takes data bits [31:28], and character k takes bits [31-4k:28-4k].
- R6: A write to offset 0x418 + 8*k, for k from 0 to 7, sets display character k (`disp_o[8k+7:8k]`) to bits [7:0] of the data. The other seven characters are left unchanged.
- R7: A write to 0x500 with data exactly 0x00000042 raises `soft_rst_req` for exactly one cycle, starting at the clock edge that accepts the write. Any other data value written to 0x500 leaves the output low.
- R8: Offset 0x508 (break/reset) and offset 0xA00 (GP output) each store bits [7:0] of a write, and a read returns the stored byte zero-extended.
- R9: Offset 0xB08 stores data bits [1:0] as the output-enable and drives them on `i2c_oe_o`. Offset 0xB10 stores bits [1:0], with bit 1 driving `scl_o` and bit 0 driving `sda_o`. Offset 0xB18 stores bit 0 as the select. Each of these reads back its stored bits.
- R10: A read of 0xB00 returns {30'b0, 1'b1, `sda_in`}. A read of 0xA08 returns the stored two-wire output bits when select is 1, and 0 when select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Byte offset for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| sda_in | input | 1 | Data bit returned by the EEPROM |
| led_o | output | 8 | LED bar bits |
| disp_o | output | 64 | Eight display characters, character k at bits [8k+7:8k] |
| soft_rst_req | output | 1 | One-cycle board reset request |
| scl_o | output | 1 | Two-wire clock line |
| sda_o | output | 1 | Two-wire data line |
| i2c_oe_o | output | 2 | Stored two-wire output-enable bits |

## Verification
The display path is driven in three ways: random word writes, random single-character writes at random indices, and directed word values of all zeros, all ones, 0x0123ABCD and 0x89ABCDEF. Together these separate a wrong nibble order, a digit-versus-letter boundary error at 9/A, and a character write that touches its neighbours. The soft-reset trigger is given 0x42, 0x142 and 0x43, which separates a full-word compare from a low-byte compare and a one-cycle pulse from a level. The two-wire readback is exercised with `sda_in` at both values and with select both set and cleared. This shows whether the merge and the select gating are done.

// File: rtl/bcr_pkg.sv
// Package: shared offsets and the hex-to-ASCII helper for the board control block.
// Assumes byte offsets that fit in the top module's ADDR_W.
package bcr_pkg;
    localparam int unsigned OFF_SWITCH   = 'h200;
    localparam int unsigned OFF_STATUS   = 'h208;
    localparam int unsigned OFF_JUMPER   = 'h210;
    localparam int unsigned OFF_LED      = 'h408;
    localparam int unsigned OFF_HEXWORD  = 'h410;
    localparam int unsigned OFF_CHAR0    = 'h418;
    localparam int unsigned CHAR_STRIDE  = 8;
    localparam int unsigned OFF_SOFTRST  = 'h500;
    localparam int unsigned OFF_BRK      = 'h508;
    localparam int unsigned OFF_GPOUT    = 'hA00;
    localparam int unsigned OFF_GPIN     = 'hA08;
    localparam int unsigned OFF_TWI_IN   = 'hB00;
    localparam int unsigned OFF_TWI_OE   = 'hB08;
    localparam int unsigned OFF_TWI_OUT  = 'hB10;
    localparam int unsigned OFF_TWI_SEL  = 'hB18;

    localparam logic [31:0] SOFTRST_KEY  = 32'h0000_0042;
    localparam logic [7:0]  BRK_RESET    = 8'h0A;
    localparam logic [7:0]  SPACE_CHAR   = 8'h20;

    // Map one nibble to its uppercase hex ASCII code.
    function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
        if (nib < 4'd10) return 8'h30 + {4'd0, nib};
        else             return 8'h41 + {4'd0, nib} - 8'd10;
    endfunction
endpackage

// File: rtl/bcr_disp_buf.sv
// Display text buffer: NCHAR characters, loaded whole from a hex word or one
// character at a time. Assumes char_sel is one-hot or zero and that word_we and
// char_sel are never active together (the decoder guarantees this).
module bcr_disp_buf
    import bcr_pkg::*;
#(
    parameter int NCHAR  = 8,
    parameter int CHAR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_we,
    input  logic [4*NCHAR-1:0]      word_val,
    input  logic [NCHAR-1:0]        char_sel,
    input  logic [CHAR_W-1:0]       char_val,
    output logic [NCHAR*CHAR_W-1:0] text_o
);
    localparam int WORD_W = 4 * NCHAR;

    for (genvar k = 0; k < NCHAR; k++) begin : g_char
        logic [CHAR_W-1:0] ch_q;
        logic [3:0]        nib;

        // Nibble for this position: character 0 takes the most significant one.
        assign nib = word_val[WORD_W-1-4*k -: 4];

        // Character register: reset to space, load from word or direct write.
        always_ff @(posedge clk) begin
            if (!rst_n)           ch_q <= CHAR_W'(SPACE_CHAR);
            else if (word_we)     ch_q <= CHAR_W'(nib_to_ascii(nib));
            else if (char_sel[k]) ch_q <= char_val;
        end

        assign text_o[CHAR_W*k +: CHAR_W] = ch_q;
    end
endmodule

// File: rtl/bcr_twi_regs.sv
// Bit-banged two-wire control registers: output-enable, line levels and select.
// Assumes the write strobes are one-hot or zero; the stored levels drive the pins.
module bcr_twi_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oe_we,
    input  logic       out_we,
    input  logic       sel_we,
    input  logic [1:0] wbits,
    output logic [1:0] oe_q,
    output logic [1:0] out_q,
    output logic       sel_q
);
    // Output-enable register, two bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     oe_q <= 2'b00;
        else if (oe_we) oe_q <= wbits;
    end

    // Line level register: bit 1 is the clock line, bit 0 the data line.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= 2'b11;
        else if (out_we) out_q <= wbits;
    end

    // Select register, one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= 1'b1;
        else if (sel_we) sel_q <= wbits[0];
    end
endmodule

// File: rtl/bcr_read_mux.sv
// Combinational read-back multiplexer. Unmapped offsets, switches and jumpers
// read zero. Assumes register fields arrive already stored; no state here.
module bcr_read_mux
    import bcr_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        led_q,
    input  logic [7:0]        brk_q,
    input  logic [7:0]        gpout_q,
    input  logic [1:0]        twi_oe_q,
    input  logic [1:0]        twi_out_q,
    input  logic              twi_sel_q,
    input  logic              sda_in,
    output logic [31:0]       rdata
);
    localparam logic [31:0] STATUS_VAL = BIG_ENDIAN ? 32'h12 : 32'h10;
    localparam logic        TWI_IN_HI  = 1'b1;

    // Select the read value for the current offset.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_STATUS):  rdata = STATUS_VAL;
            ADDR_W'(OFF_LED):     rdata = {24'd0, led_q};
            ADDR_W'(OFF_BRK):     rdata = {24'd0, brk_q};
            ADDR_W'(OFF_GPOUT):   rdata = {24'd0, gpout_q};
            ADDR_W'(OFF_GPIN):    rdata = twi_sel_q ? {30'd0, twi_out_q} : 32'd0;
            ADDR_W'(OFF_TWI_IN):  rdata = {30'd0, TWI_IN_HI, sda_in};
            ADDR_W'(OFF_TWI_OE):  rdata = {30'd0, twi_oe_q};
            ADDR_W'(OFF_TWI_OUT): rdata = {30'd0, twi_out_q};
            ADDR_W'(OFF_TWI_SEL): rdata = {31'd0, twi_sel_q};
            default:              rdata = '0;
        endcase
    end
endmodule

// File: rtl/board_ctl_regs.sv
// Board control register block: offset decode, LED/break/GP bytes, soft-reset
// pulse, display buffer and two-wire registers. Assumes one access per cycle,
// full offset match (misaligned offsets are unmapped), 32-bit data.
module board_ctl_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              sda_in,
    output logic [7:0]        led_o,
    output logic [63:0]       disp_o,
    output logic              soft_rst_req,
    output logic              scl_o,
    output logic              sda_o,
    output logic [1:0]        i2c_oe_o
);
    localparam int NCHAR  = 8;
    localparam int CHAR_W = 8;

    logic [7:0]       led_q, brk_q, gpout_q;
    logic [NCHAR-1:0] char_sel;
    logic [1:0]       twi_oe_q, twi_out_q;
    logic             twi_sel_q;
    logic             hit_led, hit_brk, hit_gpout, hit_word, hit_rst;
    logic             hit_oe, hit_out, hit_sel;

    // Write decode: each strobe is the write enable qualified by an exact offset.
    assign hit_led   = wr_en && (addr == ADDR_W'(OFF_LED));
    assign hit_brk   = wr_en && (addr == ADDR_W'(OFF_BRK));
    assign hit_gpout = wr_en && (addr == ADDR_W'(OFF_GPOUT));
    assign hit_word  = wr_en && (addr == ADDR_W'(OFF_HEXWORD));
    assign hit_rst   = wr_en && (addr == ADDR_W'(OFF_SOFTRST));
    assign hit_oe    = wr_en && (addr == ADDR_W'(OFF_TWI_OE));
    assign hit_out   = wr_en && (addr == ADDR_W'(OFF_TWI_OUT));
    assign hit_sel   = wr_en && (addr == ADDR_W'(OFF_TWI_SEL));

    for (genvar k = 0; k < NCHAR; k++) begin : g_csel
        // Per-character strobe at its own stride-spaced offset.
        assign char_sel[k] = wr_en &&
            (addr == ADDR_W'(OFF_CHAR0 + CHAR_STRIDE * k));
    end

    // LED bar byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       led_q <= 8'h00;
        else if (hit_led) led_q <= wdata[7:0];
    end

    // Break/reset byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       brk_q <= BRK_RESET;
        else if (hit_brk) brk_q <= wdata[7:0];
    end

    // General-purpose output byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         gpout_q <= 8'h00;
        else if (hit_gpout) gpout_q <= wdata[7:0];
    end

    // Soft-reset request: one-cycle pulse on an exact key match.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst_req <= 1'b0;
        else        soft_rst_req <= hit_rst && (wdata == SOFTRST_KEY);
    end

    bcr_disp_buf #(
        .NCHAR  (NCHAR),
        .CHAR_W (CHAR_W)
    ) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_we  (hit_word),
        .word_val (wdata),
        .char_sel (char_sel),
        .char_val (wdata[CHAR_W-1:0]),
        .text_o   (disp_o)
    );

    bcr_twi_regs u_twi (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_we  (hit_oe),
        .out_we (hit_out),
        .sel_we (hit_sel),
        .wbits  (wdata[1:0]),
        .oe_q   (twi_oe_q),
        .out_q  (twi_out_q),
        .sel_q  (twi_sel_q)
    );

    bcr_read_mux #(
        .ADDR_W     (ADDR_W),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_rmux (
        .addr      (addr),
        .led_q     (led_q),
        .brk_q     (brk_q),
        .gpout_q   (gpout_q),
        .twi_oe_q  (twi_oe_q),
        .twi_out_q (twi_out_q),
        .twi_sel_q (twi_sel_q),
        .sda_in    (sda_in),
        .rdata     (rdata)
    );

    assign led_o    = led_q;
    assign scl_o    = twi_out_q[1];
    assign sda_o    = twi_out_q[0];
    assign i2c_oe_o = twi_oe_q;
endmodule

// File: rtl/bcr_checker.sv
// Temporal checks on the board control block's ports, bound to every instance.
module bcr_checker #(
    parameter int ADDR_W     = 20,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [7:0]        led_o,
    input logic [63:0]       disp_o,
    input logic              soft_rst_req,
    input logic              scl_o,
    input logic              sda_o
);
    localparam logic [31:0] EXP_STATUS = BIG_ENDIAN ? 32'h12 : 32'h10;

    assert_rst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |=> !soft_rst_req);

    assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> ($past(wr_en) && $past(addr) == ADDR_W'('h500)
                          && $past(wdata) == 32'h42));

    assert_led_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_o) |-> ($past(wr_en) && $past(addr) == ADDR_W'('h408)));

    assert_disp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_o) |-> ($past(wr_en) &&
            ($past(addr) == ADDR_W'('h410) ||
             ($past(addr) >= ADDR_W'('h418) && $past(addr) <= ADDR_W'('h450)))));

    assert_lines_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(scl_o) && $stable(sda_o)) |->
            ($past(wr_en) && $past(addr) == ADDR_W'('hB10)));

    assert_zero_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'('h200) || addr == ADDR_W'('h210)) |-> rdata == 32'd0);

    assert_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'('h208)) |-> rdata == EXP_STATUS);
endmodule

bind board_ctl_regs bcr_checker #(
    .ADDR_W     (ADDR_W),
    .BIG_ENDIAN (BIG_ENDIAN)
) u_bcr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .led_o        (led_o),
    .disp_o       (disp_o),
    .soft_rst_req (soft_rst_req),
    .scl_o        (scl_o),
    .sda_o        (sda_o)
);

// File: tb/tb_board_ctl_regs.sv
// Bench: directed corners plus seeded random writes, checked against a bench model.
module tb_board_ctl_regs;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              sda_in = 1'b0;
    logic [7:0]        led_o;
    logic [63:0]       disp_o;
    logic              soft_rst_req;
    logic              scl_o, sda_o;
    logic [1:0]        i2c_oe_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0]  m_led, m_brk, m_gp;
    logic [63:0] m_disp;

    always #10 clk = ~clk;

    board_ctl_regs #(.ADDR_W(ADDR_W), .BIG_ENDIAN(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sda_in(sda_in), .led_o(led_o), .disp_o(disp_o),
        .soft_rst_req(soft_rst_req), .scl_o(scl_o), .sda_o(sda_o),
        .i2c_oe_o(i2c_oe_o)
    );

    function automatic logic [7:0] hexc(input logic [3:0] n);
        return (n < 10) ? (8'd48 + 8'(n)) : (8'd55 + 8'(n));
    endfunction

    function automatic logic [63:0] hex_text(input logic [31:0] v);
        logic [63:0] t;
        for (int k = 0; k < 8; k++) t[8*k +: 8] = hexc(v[31-4*k -: 4]);
        return t;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write: drive at falling edge, captured at the next rising edge.
    task automatic wr(input int unsigned off, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(off); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input int unsigned off, output logic [31:0] d);
        @(negedge clk);
        addr = ADDR_W'(off);
        #1 d = rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic [31:0] v;
        int          pulses;
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check("R1 led", 64'(led_o), 64'h00);
        check("R1 disp", disp_o, {8{8'h20}});
        check("R1 rst", 64'(soft_rst_req), 64'd0);
        check("R1 scl/sda", 64'({scl_o, sda_o}), 64'h3);
        check("R1 oe", 64'(i2c_oe_o), 64'h0);
        rd('h508, r); check("R1 brk", 64'(r), 64'h0A);
        rd('hA00, r); check("R1 gpout", 64'(r), 64'h00);
        rd('hB18, r); check("R1 sel", 64'(r), 64'h1);
        m_led = 8'h00; m_brk = 8'h0A; m_gp = 8'h00; m_disp = {8{8'h20}};

        // R3 status, little-endian configuration
        rd('h208, r); check("R3 status", 64'(r), 64'h10);

        // R2 switches, jumpers and unmapped offsets
        wr('h408, 32'h5A); m_led = 8'h5A;
        wr('h200, 32'hFFFF_FFFF); rd('h200, r); check("R2 switch", 64'(r), 64'd0);
        wr('h210, 32'hFFFF_FFFF); rd('h210, r); check("R2 jumper", 64'(r), 64'd0);
        wr('h40C, 32'hFF); wr('h419, 32'h41); wr('h458, 32'h41);
        rd('h40C, r); check("R2 unmapped read", 64'(r), 64'd0);
        check("R2 led untouched", 64'(led_o), 64'(m_led));
        check("R2 disp untouched", disp_o, m_disp);
        rd('h508, r); check("R2 brk untouched", 64'(r), 64'(m_brk));

        // R4 LED low byte only
        wr('h408, 32'hDEAD_BEC3); m_led = 8'hC3;
        check("R4 led port", 64'(led_o), 64'hC3);
        rd('h408, r); check("R4 led read", 64'(r), 64'hC3);

        // R5 directed word values
        foreach (r[i]) begin end
        wr('h410, 32'h0000_0000); m_disp = hex_text(32'h0);
        check("R5 zeros", disp_o, m_disp);
        wr('h410, 32'hFFFF_FFFF); m_disp = hex_text(32'hFFFF_FFFF);
        check("R5 ones", disp_o, m_disp);
        wr('h410, 32'h0123_ABCD); check("R5 mixed", disp_o, 64'h4443_4241_3332_3130);
        wr('h410, 32'h89AB_CDEF); m_disp = hex_text(32'h89AB_CDEF);
        check("R5 9/A edge", disp_o, m_disp);

        // R6 single characters at both ends
        wr('h418, 32'h123_4561); m_disp[7:0] = 8'h61;
        check("R6 char0", disp_o, m_disp);
        wr('h450, 32'h7A); m_disp[63:56] = 8'h7A;
        check("R6 char7", disp_o, m_disp);

        // R7 soft reset key
        pulses = 0;
        @(negedge clk); wr_en = 1'b1; addr = ADDR_W'('h500); wdata = 32'h142;
        @(negedge clk); wr_en = 1'b0; pulses += int'(soft_rst_req);
        @(negedge clk); pulses += int'(soft_rst_req);
        check("R7 wide value ignored", 64'(pulses), 64'd0);
        wr('h500, 32'h43); check("R7 other value", 64'(soft_rst_req), 64'd0);
        @(negedge clk); wr_en = 1'b1; addr = ADDR_W'('h500); wdata = 32'h42;
        @(negedge clk); wr_en = 1'b0;
        check("R7 pulse high", 64'(soft_rst_req), 64'd1);
        @(negedge clk); check("R7 pulse one cycle", 64'(soft_rst_req), 64'd0);

        // R9 and R10 two-wire registers
        wr('hB08, 32'hFFFF_FFFE); check("R9 oe", 64'(i2c_oe_o), 64'h2);
        rd('hB08, r); check("R9 oe read", 64'(r), 64'h2);
        wr('hB10, 32'h2); check("R9 lines 10", 64'({scl_o, sda_o}), 64'h2);
        wr('hB10, 32'h1); check("R9 lines 01", 64'({scl_o, sda_o}), 64'h1);
        rd('hA08, r); check("R10 gpin sel=1", 64'(r), 64'h1);
        sda_in = 1'b0; rd('hB00, r); check("R10 in sda=0", 64'(r), 64'h2);
        sda_in = 1'b1; rd('hB00, r); check("R10 in sda=1", 64'(r), 64'h3);
        wr('hB18, 32'h2); rd('hB18, r); check("R9 sel write", 64'(r), 64'h0);
        rd('hA08, r); check("R10 gpin sel=0", 64'(r), 64'h0);

        // Random mix against the model (R4 R5 R6 R8)
        for (int it = 0; it < 300; it++) begin
            int unsigned op = $urandom % 5;
            v = $urandom;
            case (op)
                0: begin wr('h408, v); m_led = v[7:0]; end
                1: begin wr('h410, v); m_disp = hex_text(v); end
                2: begin
                    int unsigned k = $urandom % 8;
                    wr('h418 + 8*k, v); m_disp[8*k +: 8] = v[7:0];
                end
                3: begin wr('h508, v); m_brk = v[7:0]; end
                default: begin wr('hA00, v); m_gp = v[7:0]; end
            endcase
            check("R4 rnd led", 64'(led_o), 64'(m_led));
            check("R5/R6 rnd disp", disp_o, m_disp);
            rd('h508, r); check("R8 rnd brk", 64'(r), 64'(m_brk));
            rd('hA00, r); check("R8 rnd gpout", 64'(r), 64'(m_gp));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule